// File: doc/BRIEF.md
# SPI Master Register Front-End

This block sits between a word-wide register bus and the serial frame engine of an SPI master. It decodes five word registers: a data port, two control words, a status word and a clock-divider word. It also holds a transmit FIFO and a receive FIFO of 128 words each. A bus write to the data port queues a word for the engine. A bus read of the same address takes the oldest received word. The engine pulls transmit words and pushes received words through its own strobes, and it reads its configuration from dedicated outputs.

Software empties either FIFO by setting a flush bit in control-0. A two-state flush sequencer, `FL_IDLE` and `FL_CLEAR`, latches the request. The transition `FL_IDLE -> FL_CLEAR` happens on a control-0 write that has at least one flush bit set. While the sequencer is in `FL_CLEAR`, the requested FIFO pointers are reset and the flush bits read back as 1. The transition `FL_CLEAR -> FL_IDLE` happens on the next edge, unless a new flush write arrives in that cycle; in that case the sequencer stays in `FL_CLEAR`. Underrun and overrun are sticky status bits. Software clears each one by writing 0 to its position.

Top module: `spi_fe_top`

## Requirements
- R1: After reset, control-0, control-1 and the divider read 0, the frame-length output is 2, the engine sees no transmit word, and status reads 0x90 while `eng_busy` is low.
- R2: A bus write to offset 0x00 appends the word to the transmit FIFO, and the engine receives the words in write order. Status bit 5 is 1 when 128 words are held, and a write to a full FIFO is dropped.
- R3: A bus read of offset 0x00 returns the oldest received word and removes it. A read of an empty receive FIFO returns 0 and changes nothing.
- R4: Control-0 (offset 0x04) stores five fields: bit 15 enable, bit 10 loopback, bit 6 chip-select-1, bit 19 transmit LSB-first and bit 17 receive LSB-first. These fields read back and drive `cfg_enable`, `cfg_loopback`, `cfg_cs1`, `cfg_lsb_tx` and `cfg_lsb_rx`.
- R5: Writing 1 to control-0 bit 2 flushes the transmit FIFO and writing 1 to bit 1 flushes the receive FIFO. The bit reads 1 for exactly one cycle after the write, then reads 0, and the FIFO is then empty. A FIFO whose flush bit is not set keeps its contents.
- R6: Control-1 (offset 0x08) bits 7:3 hold n. `cfg_frame_bits` equals n+2 (2 to 33), and all other control-1 bits read 0.
- R7: The divider (offset 0x18) stores its low 8 bits, drives them on `cfg_div` and reads 0 in bits 31:8.
- R8: Status (offset 0x0C) bit 4 is 1 when the receive FIFO is empty. Bit 2 is 1 when the receive FIFO holds 64 words or more.
- R9: Status bit 1 (underrun) is set when the engine takes from an empty transmit FIFO. It stays set until a status write with bit 1 equal to 0, and a status write with bit 1 equal to 1 leaves it set.
- R10: Status bit 0 (overrun) is set when the engine pushes into a full receive FIFO, and that word is dropped. It clears like bit 1.
- R11: Status bit 6 follows `eng_busy`. Bit 7 is 1 only when the transmit FIFO is empty and `eng_busy` is low.
- R12: Offsets outside the five registers read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on data offset) |
| bus_addr | input | 5 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| eng_tx_avail | output | 1 | Transmit FIFO not empty |
| eng_tx_data | output | 32 | Oldest transmit word |
| eng_tx_take | input | 1 | Engine takes a transmit word |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word |
| eng_busy | input | 1 | Engine is shifting |
| cfg_enable | output | 1 | Controller enable |
| cfg_loopback | output | 1 | Internal loopback |
| cfg_cs1 | output | 1 | Use chip select 1 |
| cfg_lsb_tx | output | 1 | Transmit LSB first |
| cfg_lsb_rx | output | 1 | Receive LSB first |
| cfg_frame_bits | output | 6 | Bits per frame |
| cfg_div | output | 8 | Clock divider value d; SCK = clk/(2(d+1)) |

## Verification
The hardest conditions to reach from the ports are the boundary states of the 128-word FIFOs: the exact push that raises the full flag, the 64th received word that raises half-full, and the extra word that is dropped. The bench sweeps every fill level from empty to two words past full on both FIFOs and checks the flags after each step. It then drains both FIFOs past empty, which produces underrun and reads of an empty FIFO. The single-cycle flush window is caught by reading control-0 in the cycle right after the flush write, and again one cycle later.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
    localparam logic [4:0] OFF_DATA = 5'h00;
    localparam logic [4:0] OFF_CTL0 = 5'h04;
    localparam logic [4:0] OFF_CTL1 = 5'h08;
    localparam logic [4:0] OFF_STAT = 5'h0C;
    localparam logic [4:0] OFF_DIV  = 5'h18;

    localparam int C0_LSB_TX = 19;
    localparam int C0_LSB_RX = 17;
    localparam int C0_EN     = 15;
    localparam int C0_LOOP   = 10;
    localparam int C0_CS1    = 6;
    localparam int C0_FL_TX  = 2;
    localparam int C0_FL_RX  = 1;

    localparam int C1_FLEN_LO = 3;

    localparam int ST_END    = 7;
    localparam int ST_BUSY   = 6;
    localparam int ST_TXFULL = 5;
    localparam int ST_RXEMPT = 4;
    localparam int ST_RXHALF = 2;
    localparam int ST_URUN   = 1;
    localparam int ST_OVR    = 0;

    typedef enum logic {
        FL_IDLE,
        FL_CLEAR
    } flush_state_e;
endpackage

// File: rtl/spi_fe_fifo.sv
module spi_fe_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 128
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2: a push into a full FIFO leaves the fill level unchanged
    p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (count == $past(count)));

    // R3: a pop from an empty FIFO leaves it empty
    p_empty_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clr) |=> empty);

    // R5: a clear empties the FIFO on the next edge
    p_clr_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
endmodule

// File: rtl/spi_fe_flush_fsm.sv
module spi_fe_flush_fsm
    import spi_fe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_wr,
    input  logic req_tx,
    input  logic req_rx,
    output logic tx_clr,
    output logic rx_clr
);
    flush_state_e state_q, state_d;
    logic         mask_tx_q, mask_rx_q;
    logic         start;

    assign start = req_wr && (req_tx || req_rx);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE:  if (start) state_d = FL_CLEAR;
            FL_CLEAR: state_d = start ? FL_CLEAR : FL_IDLE;
            default:  state_d = FL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= FL_IDLE;
            mask_tx_q <= 1'b0;
            mask_rx_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            mask_tx_q <= start ? req_tx : 1'b0;
            mask_rx_q <= start ? req_rx : 1'b0;
        end
    end

    always_comb begin
        tx_clr = 1'b0;
        rx_clr = 1'b0;
        unique case (state_q)
            FL_IDLE:  ;
            FL_CLEAR: begin
                tx_clr = mask_tx_q;
                rx_clr = mask_rx_q;
            end
            default:  ;
        endcase
    end

    // R5: the flush window lasts one cycle without a new request
    p_flush_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FL_CLEAR && !start) |=> (state_q == FL_IDLE));
endmodule

// File: rtl/spi_fe_top.sv
module spi_fe_top
    import spi_fe_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 128,
    parameter int ADDR_W     = 5,
    parameter int DIV_W      = 8,
    parameter int FLEN_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              eng_tx_avail,
    output logic [DATA_W-1:0] eng_tx_data,
    input  logic              eng_tx_take,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    input  logic              eng_busy,
    output logic              cfg_enable,
    output logic              cfg_loopback,
    output logic              cfg_cs1,
    output logic              cfg_lsb_tx,
    output logic              cfg_lsb_rx,
    output logic [FLEN_W:0]   cfg_frame_bits,
    output logic [DIV_W-1:0]  cfg_div
);
    localparam int CW   = $clog2(FIFO_DEPTH + 1);
    localparam int HALF = FIFO_DEPTH / 2;

    logic sel_data, sel_c0, sel_c1, sel_st, sel_div;
    logic wr_c0, wr_st;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic tx_clr, rx_clr;
    logic [CW-1:0] tx_count, rx_count;
    logic [DATA_W-1:0] rx_head;
    logic [FLEN_W-1:0] flen_q;
    logic urun_q, ovr_q, urun_evt, ovr_evt;

    assign sel_data = (bus_addr == ADDR_W'(OFF_DATA));
    assign sel_c0   = (bus_addr == ADDR_W'(OFF_CTL0));
    assign sel_c1   = (bus_addr == ADDR_W'(OFF_CTL1));
    assign sel_st   = (bus_addr == ADDR_W'(OFF_STAT));
    assign sel_div  = (bus_addr == ADDR_W'(OFF_DIV));
    assign wr_c0    = bus_wr && sel_c0;
    assign wr_st    = bus_wr && sel_st;
    assign urun_evt = eng_tx_take && tx_empty;
    assign ovr_evt  = eng_rx_push && rx_full;

    spi_fe_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(bus_wr && sel_data), .wdata(bus_wdata),
        .pop(eng_tx_take), .rdata(eng_tx_data),
        .count(tx_count), .full(tx_full), .empty(tx_empty));

    spi_fe_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(eng_rx_push), .wdata(eng_rx_data),
        .pop(bus_rd && sel_data), .rdata(rx_head),
        .count(rx_count), .full(rx_full), .empty(rx_empty));

    spi_fe_flush_fsm u_flush (
        .clk(clk), .rst_n(rst_n), .req_wr(wr_c0),
        .req_tx(bus_wdata[C0_FL_TX]), .req_rx(bus_wdata[C0_FL_RX]),
        .tx_clr(tx_clr), .rx_clr(rx_clr));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_enable   <= 1'b0;
            cfg_loopback <= 1'b0;
            cfg_cs1      <= 1'b0;
            cfg_lsb_tx   <= 1'b0;
            cfg_lsb_rx   <= 1'b0;
            flen_q       <= '0;
            cfg_div      <= '0;
            urun_q       <= 1'b0;
            ovr_q        <= 1'b0;
        end else begin
            if (wr_c0) begin
                cfg_enable   <= bus_wdata[C0_EN];
                cfg_loopback <= bus_wdata[C0_LOOP];
                cfg_cs1      <= bus_wdata[C0_CS1];
                cfg_lsb_tx   <= bus_wdata[C0_LSB_TX];
                cfg_lsb_rx   <= bus_wdata[C0_LSB_RX];
            end
            if (bus_wr && sel_c1)  flen_q  <= bus_wdata[C1_FLEN_LO +: FLEN_W];
            if (bus_wr && sel_div) cfg_div <= bus_wdata[DIV_W-1:0];
            urun_q <= (urun_q && !(wr_st && !bus_wdata[ST_URUN])) || urun_evt;
            ovr_q  <= (ovr_q && !(wr_st && !bus_wdata[ST_OVR])) || ovr_evt;
        end
    end

    assign cfg_frame_bits = {1'b0, flen_q} + (FLEN_W+1)'(2);
    assign eng_tx_avail   = !tx_empty;

    always_comb begin
        bus_rdata = '0;
        if (sel_data) begin
            bus_rdata = rx_head;
        end else if (sel_c0) begin
            bus_rdata[C0_EN]     = cfg_enable;
            bus_rdata[C0_LOOP]   = cfg_loopback;
            bus_rdata[C0_CS1]    = cfg_cs1;
            bus_rdata[C0_LSB_TX] = cfg_lsb_tx;
            bus_rdata[C0_LSB_RX] = cfg_lsb_rx;
            bus_rdata[C0_FL_TX]  = tx_clr;
            bus_rdata[C0_FL_RX]  = rx_clr;
        end else if (sel_c1) begin
            bus_rdata[C1_FLEN_LO +: FLEN_W] = flen_q;
        end else if (sel_st) begin
            bus_rdata[ST_END]    = tx_empty && !eng_busy;
            bus_rdata[ST_BUSY]   = eng_busy;
            bus_rdata[ST_TXFULL] = tx_full;
            bus_rdata[ST_RXEMPT] = rx_empty;
            bus_rdata[ST_RXHALF] = (rx_count >= CW'(HALF));
            bus_rdata[ST_URUN]   = urun_q;
            bus_rdata[ST_OVR]    = ovr_q;
        end else if (sel_div) begin
            bus_rdata[DIV_W-1:0] = cfg_div;
        end
    end

    // R9: underrun stays set unless cleared by a zero write
    p_urun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (urun_q && !(wr_st && !bus_wdata[ST_URUN])) |=> urun_q);

    // R9: a zero write without a new event clears underrun
    p_urun_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_st && !bus_wdata[ST_URUN] && !(eng_tx_take && tx_empty)) |=> !urun_q);

    // R10: a push into a full receive FIFO raises overrun
    p_ovr_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && rx_full) |=> ovr_q);

    // R5: a transmit flush leaves the engine without data
    p_tx_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clr |=> !eng_tx_avail);
endmodule

// File: tb/test_spi_fe_top.sv
module test_spi_fe_top;
    localparam logic [4:0] A_DATA = 5'h00;
    localparam logic [4:0] A_C0   = 5'h04;
    localparam logic [4:0] A_C1   = 5'h08;
    localparam logic [4:0] A_ST   = 5'h0C;
    localparam logic [4:0] A_DIV  = 5'h18;
    localparam int DEPTH = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        eng_tx_avail, eng_tx_take = 1'b0, eng_rx_push = 1'b0, eng_busy = 1'b0;
    logic [31:0] eng_tx_data, eng_rx_data = '0;
    logic        cfg_enable, cfg_loopback, cfg_cs1, cfg_lsb_tx, cfg_lsb_rx;
    logic [5:0]  cfg_frame_bits;
    logic [7:0]  cfg_div;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    spi_fe_top i_spi_fe_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_tx_avail(eng_tx_avail), .eng_tx_data(eng_tx_data),
        .eng_tx_take(eng_tx_take), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .eng_busy(eng_busy),
        .cfg_enable(cfg_enable), .cfg_loopback(cfg_loopback), .cfg_cs1(cfg_cs1),
        .cfg_lsb_tx(cfg_lsb_tx), .cfg_lsb_rx(cfg_lsb_rx),
        .cfg_frame_bits(cfg_frame_bits), .cfg_div(cfg_div));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic eng_take(output logic [31:0] d);
        eng_tx_take = 1'b1;
        #1 d = eng_tx_data;
        @(negedge clk);
        eng_tx_take = 1'b0;
    endtask

    task automatic eng_put(input logic [31:0] d);
        eng_rx_push = 1'b1; eng_rx_data = d;
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    initial begin
        #1_200_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(A_ST, v);  check("R1 status", v, 32'h90);
        bus_read(A_C0, v);  check("R1 ctl0", v, 0);
        bus_read(A_C1, v);  check("R1 ctl1", v, 0);
        bus_read(A_DIV, v); check("R1 div", v, 0);
        check("R1 frame", 32'(cfg_frame_bits), 2);
        check("R1 avail", 32'(eng_tx_avail), 0);

        // R2 transmit fill sweep past full
        for (int i = 0; i < DEPTH + 2; i++) begin
            bus_write(A_DATA, 32'(i * 7 + 3));
            bus_read(A_ST, v);
            check("R2 txfull", 32'(v[5]), 32'((i + 1) >= DEPTH));
            check("R11 end", 32'(v[7]), 0);
        end
        // R11 busy flag
        eng_busy = 1'b1;
        bus_read(A_ST, v); check("R11 busy", 32'(v[6]), 1);
        eng_busy = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            eng_take(v);
            check("R2 order", v, 32'(i * 7 + 3));
        end
        check("R2 drained", 32'(eng_tx_avail), 0);
        bus_read(A_ST, v); check("R9 no underrun yet", 32'(v[1]), 0);

        // R9 underrun
        eng_take(v);
        bus_read(A_ST, v); check("R9 underrun set", 32'(v[1]), 1);
        check("R11 end idle", 32'(v[7]), 1);
        bus_write(A_ST, 32'h2);
        bus_read(A_ST, v); check("R9 write one keeps", 32'(v[1]), 1);
        bus_write(A_ST, 32'h0);
        bus_read(A_ST, v); check("R9 write zero clears", 32'(v[1]), 0);

        // R8 and R10 receive fill sweep
        for (int i = 0; i < DEPTH + 2; i++) begin
            eng_put(32'hA500_0000 + 32'(i));
            bus_read(A_ST, v);
            check("R8 half", 32'(v[2]), 32'((i + 1) >= DEPTH / 2));
            check("R8 empty", 32'(v[4]), 0);
            check("R10 overrun", 32'(v[0]), 32'(i >= DEPTH));
        end
        for (int i = 0; i < DEPTH; i++) begin
            bus_read(A_DATA, v);
            check("R3 order", v, 32'hA500_0000 + 32'(i));
        end
        bus_read(A_DATA, v); check("R3 empty read", v, 0);
        bus_read(A_ST, v);
        check("R8 empty", 32'(v[4]), 1);
        check("R10 sticky", 32'(v[0]), 1);
        bus_write(A_ST, 32'h0);
        bus_read(A_ST, v); check("R10 cleared", 32'(v[0]), 0);

        // R4 control-0 fields
        bus_write(A_C0, 32'hFFFF_FFF9);
        bus_read(A_C0, v); check("R4 all", v, 32'h000A_8440);
        check("R4 outs", {27'd0, cfg_enable, cfg_loopback, cfg_cs1, cfg_lsb_tx, cfg_lsb_rx}, 32'h1F);
        bus_write(A_C0, 32'h0000_0400);
        bus_read(A_C0, v); check("R4 loop only", v, 32'h400);
        check("R4 outs loop", {27'd0, cfg_enable, cfg_loopback, cfg_cs1, cfg_lsb_tx, cfg_lsb_rx}, 32'h08);

        // R5 flush transmit only
        for (int i = 0; i < 5; i++) bus_write(A_DATA, 32'(i + 100));
        for (int i = 0; i < 3; i++) eng_put(32'(i + 200));
        bus_write(A_C0, 32'h0000_8004);
        bus_read(A_C0, v); check("R5 tx flush bit high", v, 32'h8004);
        bus_read(A_C0, v); check("R5 tx flush bit low", v, 32'h8000);
        check("R5 tx emptied", 32'(eng_tx_avail), 0);
        bus_read(A_DATA, v); check("R5 rx kept", v, 200);
        // R5 flush receive
        bus_write(A_C0, 32'h0000_0002);
        bus_read(A_C0, v); check("R5 rx flush bit high", v, 32'h2);
        bus_read(A_ST, v); check("R5 rx emptied", v, 32'h90);
        bus_read(A_DATA, v); check("R5 rx read zero", v, 0);

        // R6 frame length sweep
        for (int n = 0; n < 32; n++) begin
            bus_write(A_C1, 32'hFFFF_FF07 | 32'(n << 3));
            bus_read(A_C1, v);
            check("R6 readback", v, 32'(n << 3));
            check("R6 frame bits", 32'(cfg_frame_bits), 32'(n + 2));
        end

        // R7 divider sweep
        for (int d = 0; d < 256; d++) begin
            bus_write(A_DIV, 32'h5A5A_5A00 | 32'(d));
            bus_read(A_DIV, v);
            check("R7 readback", v, 32'(d));
            check("R7 out", 32'(cfg_div), 32'(d));
        end

        // R12 unmapped offsets
        bus_write(5'h10, 32'hFFFF_FFFF);
        bus_write(5'h14, 32'hFFFF_FFFF);
        bus_write(5'h1C, 32'hFFFF_FFFF);
        bus_read(5'h10, v); check("R12 read 0x10", v, 0);
        bus_read(5'h1C, v); check("R12 read 0x1C", v, 0);
        bus_read(A_DIV, v); check("R12 div kept", v, 255);
        bus_read(A_C0, v);  check("R12 ctl0 kept", v, 0);
        bus_read(A_ST, v);  check("R12 status kept", v, 32'h90);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule